// File: doc/BRIEF.md
# Dual-Mode UART Serial Clock Generator

This block produces the serial clock and timing strobes for a UART that works either asynchronously or with a shared shift clock. A control word carries an 11-bit divisor `n` and a source-select bit. A down-counter advances once per source tick and reloads when it runs out. A source tick is either every machine-clock cycle or each rising edge of an external clock input, and that external edge is detected after a two-flop synchronizer. One pass through `n` source ticks gives two full serial-clock periods, so the output flips four times per pass.

In asynchronous mode each rising edge of the serial clock is an oversampling strobe. Every eighth rise is a bit strobe, which puts the bit period at `4n` machine cycles. In synchronous mode the serial clock is the shift clock and neither strobe fires. The control word can be changed only while the divider is halted. A write at any other time is dropped and sets a sticky error flag.

A state machine with three states (IDLE, RUN, FAULT) runs the divider. Its transitions are:
- START: IDLE to RUN, when enabled with `n >= 4`.
- REJECT: IDLE to FAULT, when enabled with `n < 4`.
- STOP: RUN to IDLE, when enable drops.
- CLEAR: FAULT to IDLE, when enable drops.

Top module: `uart_baud_gen`

## Requirements
- R1: The control word uses these bit positions: bits 10..0 hold `n` and bit 13 is the source select (0 = machine clock, 1 = external clock). `rd_data` shows `n` and the source bit in those positions, and every other bit reads 0. A write to bit 11 has no effect.
- R2: A write is accepted only when `run_en` is 0, bit 12 of the written word is 0, and one of these holds: the stored source bit is 0, or the write keeps `n` unchanged and clears the source bit. Any other write leaves the stored word unchanged. It also sets `err_wr_o` one cycle later, and the flag stays set until reset.
- R3: Synchronous reset clears the stored word, all flags and all outputs to 0.
- R4: While `run_en` is 0, all clock and strobe outputs are 0 from the next edge on. START begins with `sclk_o` low, and the first toggle comes after `q = n>>2` source ticks.
- R5: Each divisor pass has four toggle segments. Three are `q` source ticks long and the fourth is `q + (n & 3)`. The first segment is one of the three that lasts `q`. `sclk_tgl_o` pulses for one cycle in exactly the cycle where `sclk_o` changes.
- R6: In asynchronous mode (`sync_mode` = 0), `os_tick_o` pulses on each rising edge of `sclk_o`. `bit_tick_o` also pulses on every eighth rise counted from START.
- R7: In synchronous mode (`sync_mode` = 1), `os_tick_o` and `bit_tick_o` stay 0 and `sclk_o` is the shift clock.
- R8: Enabling with `n < 4` takes REJECT. In FAULT, `err_range_o` is 1 and all clock outputs stay 0 until `run_en` drops, which takes CLEAR and lowers the flag.
- R9: `err_duty_o` is 1 one cycle after `run_en` = 1 and `sync_mode` = 1 are seen with `n & 3` not 0. Otherwise it is 0.
- R10: With the external source selected, each synchronized rising edge of `ext_clk` counts as one source tick.
- R11: A write that arrives in the same cycle `run_en` rises is rejected (R2). The divider then starts with the divisor that was stored before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word to write |
| rd_data | output | 16 | Stored control word |
| run_en | input | 1 | Divider enable |
| sync_mode | input | 1 | 1 = clock-synchronous, 0 = asynchronous |
| ext_clk | input | 1 | External source clock, asynchronous |
| sclk_o | output | 1 | Serial clock / shift clock |
| sclk_tgl_o | output | 1 | One-cycle pulse on each serial clock change |
| os_tick_o | output | 1 | Oversampling strobe (asynchronous mode) |
| bit_tick_o | output | 1 | Bit-rate strobe (asynchronous mode) |
| err_range_o | output | 1 | Divisor below 4 while enabled |
| err_duty_o | output | 1 | Synchronous mode with uneven divisor |
| err_wr_o | output | 1 | Sticky write-violation flag |

## Verification
The risky overlap is a control write that lands in the same cycle the divider is enabled. The write gate and the START load both look at that one edge. The bench raises `wr_en` with a new divisor and `run_en` together at one negative edge. It then judges three things: the readback still shows the old divisor, the violation flag rises, and the first toggle arrives after the old divisor's quarter count. A second overlap is the bit strobe landing on the same cycle as an oversampling strobe. It is checked on each toggle that should carry both.

// File: rtl/brg_pkg.sv
package brg_pkg;

    localparam int unsigned BRG_WORD_W  = 16;
    localparam int unsigned BRG_SRC_BIT = 13;
    localparam int unsigned BRG_RSV_BIT = 12;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FAULT = 2'd2
    } brg_state_e;

endpackage

// File: rtl/brg_ctrl_reg.sv
module brg_ctrl_reg
    import brg_pkg::*;
#(
    parameter int unsigned WORD_W = BRG_WORD_W,
    parameter int unsigned RLD_W  = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              run_en,
    output logic [WORD_W-1:0] rd_data,
    output logic [RLD_W-1:0]  reload_o,
    output logic              ext_sel_o,
    output logic              err_wr_o
);

    logic [RLD_W-1:0] rld_q;
    logic             src_q;
    logic             viol_q;
    logic [RLD_W-1:0] wr_rld;
    logic             wr_src;
    logic             wr_rsv;
    logic             accept;
    logic             unused_bits;

    assign wr_rld      = wr_data[RLD_W-1:0];
    assign wr_src      = wr_data[BRG_SRC_BIT];
    assign wr_rsv      = wr_data[BRG_RSV_BIT];
    assign unused_bits = ^{wr_data[WORD_W-1:BRG_SRC_BIT+1], wr_data[BRG_RSV_BIT-1:RLD_W]};

    // Prescaler counts as halted only with enable low; leaving external mode
    // is allowed if the divisor is kept.
    assign accept = wr_en && !run_en && !wr_rsv &&
                    (!src_q || (!wr_src && (wr_rld == rld_q)));

    always_ff @(posedge clk) begin
        if (rst) begin
            rld_q  <= '0;
            src_q  <= 1'b0;
            viol_q <= 1'b0;
        end else if (wr_en) begin
            if (accept) begin
                rld_q <= wr_rld;
                src_q <= wr_src;
            end else begin
                viol_q <= 1'b1;
            end
        end
    end

    always_comb begin
        rd_data                   = '0;
        rd_data[RLD_W-1:0]        = rld_q;
        rd_data[BRG_SRC_BIT]      = src_q;
    end

    assign reload_o  = rld_q;
    assign ext_sel_o = src_q;
    assign err_wr_o  = viol_q;

    p_flag_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        viol_q |=> viol_q);

    p_reject_holds_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && run_en) |=> (rld_q == $past(rld_q) && src_q == $past(src_q) && viol_q));

endmodule

// File: rtl/brg_src_sel.sv
module brg_src_sel #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_clk,
    input  logic ext_sel,
    output logic tick_o
);

    localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;
    logic               ext_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], ext_clk};
        end
    end

    assign ext_rise = chain_q[SYNC_STAGES-1] && !chain_q[SYNC_STAGES];
    assign tick_o   = ext_sel ? ext_rise : 1'b1;

    p_ext_tick_single_r10: assert property (@(posedge clk) disable iff (rst)
        (ext_sel && tick_o) |=> (!tick_o || !ext_sel));

endmodule

// File: rtl/brg_divider.sv
module brg_divider
    import brg_pkg::*;
#(
    parameter int unsigned RLD_W         = 11,
    parameter int unsigned RISES_PER_BIT = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             sync_mode,
    input  logic             src_tick,
    input  logic [RLD_W-1:0] reload_i,
    output logic             sclk_o,
    output logic             sclk_tgl_o,
    output logic             os_tick_o,
    output logic             bit_tick_o,
    output logic             err_range_o,
    output logic             err_duty_o
);

    localparam int unsigned OSC_W = (RISES_PER_BIT > 1) ? $clog2(RISES_PER_BIT) : 1;
    localparam int unsigned QTR_W = RLD_W - 2;
    localparam logic [OSC_W-1:0] LAST_RISE = OSC_W'(RISES_PER_BIT - 1);

    brg_state_e       state_q;
    brg_state_e       state_d;
    logic [QTR_W-1:0] quarter;
    logic [1:0]       rem;
    logic [RLD_W-1:0] len_base;
    logic [RLD_W-1:0] len_last;
    logic             too_small;
    logic             start;
    logic             staying;
    logic [RLD_W-1:0] sub_q;
    logic [1:0]       seg_q;
    logic [OSC_W-1:0] rise_q;

    assign quarter   = reload_i[RLD_W-1:2];
    assign rem       = reload_i[1:0];
    assign len_base  = RLD_W'(quarter);
    assign len_last  = len_base + RLD_W'(rem);
    assign too_small = (reload_i < RLD_W'(4));

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: START, REJECT, STOP, CLEAR
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (run_en) begin
                    state_d = too_small ? ST_FAULT : ST_RUN;
                end
            end
            ST_RUN: begin
                if (!run_en) begin
                    state_d = ST_IDLE;
                end
            end
            ST_FAULT: begin
                if (!run_en) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign start   = (state_q == ST_IDLE) && (state_d == ST_RUN);
    assign staying = (state_q == ST_RUN) && (state_d == ST_RUN);

    // counters and outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            sub_q      <= '0;
            seg_q      <= '0;
            rise_q     <= '0;
            sclk_o     <= 1'b0;
            sclk_tgl_o <= 1'b0;
            os_tick_o  <= 1'b0;
            bit_tick_o <= 1'b0;
            err_duty_o <= 1'b0;
        end else begin
            err_duty_o <= run_en && sync_mode && (rem != 2'd0);
            sclk_tgl_o <= 1'b0;
            os_tick_o  <= 1'b0;
            bit_tick_o <= 1'b0;
            if (start) begin
                sub_q  <= len_base;
                seg_q  <= 2'd0;
                rise_q <= '0;
                sclk_o <= 1'b0;
            end else if (!staying) begin
                sub_q  <= '0;
                seg_q  <= 2'd0;
                rise_q <= '0;
                sclk_o <= 1'b0;
            end else if (src_tick) begin
                if (sub_q <= RLD_W'(1)) begin
                    sclk_o     <= !sclk_o;
                    sclk_tgl_o <= 1'b1;
                    seg_q      <= seg_q + 2'd1;
                    sub_q      <= (seg_q == 2'd2) ? len_last : len_base;
                    if (!sclk_o && !sync_mode) begin
                        os_tick_o <= 1'b1;
                        rise_q    <= (rise_q == LAST_RISE) ? '0 : rise_q + OSC_W'(1);
                        if (rise_q == LAST_RISE) begin
                            bit_tick_o <= 1'b1;
                        end
                    end
                end else begin
                    sub_q <= sub_q - RLD_W'(1);
                end
            end
        end
    end

    assign err_range_o = (state_q == ST_FAULT);

    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (!sclk_o && !sclk_tgl_o && !os_tick_o && !bit_tick_o));

    p_strobe_on_change_r5: assert property (@(posedge clk) disable iff (rst)
        sclk_tgl_o |-> (sclk_o != $past(sclk_o)));

    p_os_on_rise_r6: assert property (@(posedge clk) disable iff (rst)
        os_tick_o |-> $rose(sclk_o));

    p_bit_with_os_r6: assert property (@(posedge clk) disable iff (rst)
        bit_tick_o |-> os_tick_o);

    p_fault_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        err_range_o |-> (!sclk_o && !sclk_tgl_o));

endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
    import brg_pkg::*;
#(
    parameter int unsigned WORD_W        = BRG_WORD_W,
    parameter int unsigned RLD_W         = 11,
    parameter int unsigned SYNC_STAGES   = 2,
    parameter int unsigned RISES_PER_BIT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic              run_en,
    input  logic              sync_mode,
    input  logic              ext_clk,
    output logic              sclk_o,
    output logic              sclk_tgl_o,
    output logic              os_tick_o,
    output logic              bit_tick_o,
    output logic              err_range_o,
    output logic              err_duty_o,
    output logic              err_wr_o
);

    logic [RLD_W-1:0] reload;
    logic             ext_sel;
    logic             src_tick;

    brg_ctrl_reg #(.WORD_W(WORD_W), .RLD_W(RLD_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .run_en    (run_en),
        .rd_data   (rd_data),
        .reload_o  (reload),
        .ext_sel_o (ext_sel),
        .err_wr_o  (err_wr_o)
    );

    brg_src_sel #(.SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk     (clk),
        .rst     (rst),
        .ext_clk (ext_clk),
        .ext_sel (ext_sel),
        .tick_o  (src_tick)
    );

    brg_divider #(.RLD_W(RLD_W), .RISES_PER_BIT(RISES_PER_BIT)) u_div (
        .clk         (clk),
        .rst         (rst),
        .run_en      (run_en),
        .sync_mode   (sync_mode),
        .src_tick    (src_tick),
        .reload_i    (reload),
        .sclk_o      (sclk_o),
        .sclk_tgl_o  (sclk_tgl_o),
        .os_tick_o   (os_tick_o),
        .bit_tick_o  (bit_tick_o),
        .err_range_o (err_range_o),
        .err_duty_o  (err_duty_o)
    );

endmodule

// File: tb/tb_uart_baud_gen.sv
module tb_uart_baud_gen;

    localparam int CLK_P    = 10;
    localparam int EXT_HALF = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        run_en = 1'b0;
    logic        sync_mode = 1'b0;
    logic        ext_clk = 1'b0;
    logic        ext_on = 1'b0;
    logic        sclk_o, sclk_tgl_o, os_tick_o, bit_tick_o;
    logic        err_range_o, err_duty_o, err_wr_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    uart_baud_gen dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .run_en(run_en), .sync_mode(sync_mode), .ext_clk(ext_clk),
        .sclk_o(sclk_o), .sclk_tgl_o(sclk_tgl_o), .os_tick_o(os_tick_o),
        .bit_tick_o(bit_tick_o), .err_range_o(err_range_o), .err_duty_o(err_duty_o),
        .err_wr_o(err_wr_o)
    );

    always #(CLK_P/2) clk = ~clk;

    initial begin
        int hc;
        hc = 0;
        forever begin
            @(negedge clk);
            if (ext_on) begin
                hc++;
                if (hc == EXT_HALF) begin
                    ext_clk = ~ext_clk;
                    hc = 0;
                end
            end
        end
    end

    function automatic int exp_gap(input int n, input int idx);
        return (((idx - 1) % 4) == 3) ? (n / 4 + n % 4) : (n / 4);
    endfunction

    function automatic bit exp_bit(input bit syn, input int idx);
        return !syn && ((idx % 16) == 15);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic wr(input logic [15:0] w);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_seq(input int n, input bit syn, input bit ext, input int ntog);
        int c, last, seen, mul;
        mul = ext ? 2 * EXT_HALF : 1;
        sync_mode = syn;
        run_en = 1'b1;
        c = 0; last = 1; seen = 0;
        while (seen < ntog && c < 20000) begin
            @(negedge clk);
            c++;
            if (c == 2) chk(err_duty_o == (syn && (n % 4 != 0)), "R9 duty flag", err_duty_o, int'(syn && (n % 4 != 0)));
            if (sclk_tgl_o) begin
                seen++;
                if (!ext || seen > 1)
                    chk((c - last) == exp_gap(n, seen) * mul, (seen == 1) ? "R4 first toggle" : (ext ? "R10 ext gap" : "R5 gap"),
                        c - last, exp_gap(n, seen) * mul);
                chk(sclk_o == seen[0], "R5 level", sclk_o, seen[0]);
                chk(os_tick_o == (!syn && seen[0]), syn ? "R7 no os tick" : "R6 os tick", os_tick_o, int'(!syn && seen[0]));
                chk(bit_tick_o == exp_bit(syn, seen), syn ? "R7 no bit tick" : "R6 bit tick", bit_tick_o, int'(exp_bit(syn, seen)));
                last = c;
            end else begin
                chk(!os_tick_o && !bit_tick_o, "R6 stray strobe", os_tick_o + bit_tick_o, 0);
            end
        end
        chk(seen == ntog, "R5 toggle count", seen, ntog);
        run_en = 1'b0;
        @(negedge clk);
        chk(!sclk_o && !sclk_tgl_o && !os_tick_o && !bit_tick_o, "R4 idle quiet",
            {sclk_o, sclk_tgl_o, os_tick_o, bit_tick_o}, 0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rd_data == 16'h0000, "R3 word cleared", rd_data, 0);
        chk(!sclk_o && !sclk_tgl_o && !os_tick_o && !bit_tick_o, "R3 outputs low",
            {sclk_o, sclk_tgl_o, os_tick_o, bit_tick_o}, 0);
        chk(!err_range_o && !err_duty_o && !err_wr_o, "R3 flags low",
            {err_range_o, err_duty_o, err_wr_o}, 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int c;
        void'($urandom(32'd4242));
        do_reset();

        // R1: bit 11 ignored, divisor placed in bits 10..0
        wr(16'h0800 | 16'd12);
        chk(rd_data == 16'd12, "R1 readback", rd_data, 12);

        run_seq(12, 1'b0, 1'b0, 34);
        wr(16'd16);
        run_seq(16, 1'b1, 1'b0, 10);
        wr(16'd7);
        run_seq(7, 1'b0, 1'b0, 32);

        for (int it = 0; it < 6; it++) begin
            int n;
            bit syn;
            n = 4 + int'($urandom_range(60, 0));
            syn = $urandom_range(1, 0) == 1;
            if (syn) n = n & ~3;
            wr(16'(n));
            chk(rd_data == 16'(n), "R1 random readback", rd_data, n);
            run_seq(n, syn, 1'b0, 18);
        end

        // R8: divisors below 4
        for (int v = 0; v < 4; v++) begin
            wr(16'(v));
            run_en = 1'b1;
            repeat (2) @(negedge clk);
            chk(err_range_o == 1'b1, "R8 range flag", err_range_o, 1);
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                chk(!sclk_o && !sclk_tgl_o && !os_tick_o, "R8 outputs idle",
                    {sclk_o, sclk_tgl_o, os_tick_o}, 0);
            end
            run_en = 1'b0;
            @(negedge clk);
            chk(err_range_o == 1'b0, "R8 clear", err_range_o, 0);
        end

        // R9: uneven divisor in synchronous mode
        wr(16'd6);
        run_seq(6, 1'b1, 1'b0, 8);

        // R10: external source
        wr(16'h2000 | 16'd8);
        chk(rd_data == 16'h2008, "R1 source bit", rd_data, 16'h2008);
        ext_on = 1'b1;
        run_seq(8, 1'b0, 1'b1, 12);
        ext_on = 1'b0;
        wr(16'h0008);
        chk(rd_data == 16'h0008, "R2 leave external", rd_data, 8);
        chk(err_wr_o == 1'b0, "R2 no violation yet", err_wr_o, 0);

        // R11: write in the same cycle as enable
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = 16'd12;
        run_en = 1'b1;
        sync_mode = 1'b0;
        c = 0;
        do begin
            @(negedge clk);
            wr_en = 1'b0;
            c++;
        end while (!sclk_tgl_o && c < 100);
        chk(c == 3, "R11 old divisor used", c, 3);
        chk(rd_data == 16'h0008, "R11 write dropped", rd_data, 8);
        chk(err_wr_o == 1'b1, "R11 violation", err_wr_o, 1);
        run_en = 1'b0;
        @(negedge clk);

        // R2: external source held blocks divisor change; reserved bit
        wr(16'h2008);
        wr(16'd12);
        chk(rd_data == 16'h2008, "R2 rejected in external", rd_data, 16'h2008);
        wr(16'h0008);
        wr(16'h1000 | 16'd20);
        chk(rd_data == 16'h0008, "R2 reserved bit rejected", rd_data, 8);
        repeat (3) @(negedge clk);
        chk(err_wr_o == 1'b1, "R2 sticky", err_wr_o, 1);

        do_reset();

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule